// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the instruction fetch address of a small processor core and chooses its next value on every clock edge. Sequential fetch steps the address by one when the core asserts its advance strobe. The upper part of the address can never be loaded on its own. It changes only in two ways. When software writes the readable low byte, all upper bits are copied from a separate 5-bit page latch. When a jump or call is taken, the top two bits come from that latch and the rest come from the opcode target field.

A return strobe loads the whole address from a value popped off an external stack, and the page latch plays no part in that load. The page latch has its own write port. Decode, the ALU and the stack storage live outside the block. The only thing software can read is the low byte, which is provided as a separate output.

Top module: `pgpc_unit`

## Requirements
- R1: An active-low reset (rst_n = 0) clears both the 13-bit address and the page latch to zero. A low-byte write of D made right after reset yields the address 0x00D (upper bits 0).
- R2: When no load strobe (ret, jmp, lo_we) is active and adv = 1, the address steps by one at the next clock edge. The carry propagates into bits 12:8, and 0x1FFF wraps to 0x0000.
- R3: When no strobe at all is active, the address keeps its value.
- R4: A low-byte write (lo_we = 1) with data D loads the address with {latch[4:0], D} at the next edge. The latch value used is the one held before that edge, even if lat_we is active in the same cycle.
- R5: A jump or call (jmp = 1) with target T loads the address with {latch[4:3], T[10:0]}.
- R6: A return (ret = 1) loads all 13 address bits from ret_addr, whatever the latch holds.
- R7: Returns, jumps and low-byte writes leave the page latch unchanged. Only lat_we writes lat_wdata into it, and it takes effect for strobes in later cycles.
- R8: When strobes coincide, the priority is ret over jmp, then jmp over lo_we, then lo_we over adv.
- R9: pc_lo always equals bits 7:0 of pc.
- R10: Writing the page latch on its own never changes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Advance strobe for sequential fetch |
| lo_we | input | 1 | Low-byte write strobe |
| lo_wdata | input | 8 | Low-byte write data |
| lat_we | input | 1 | Page latch write strobe |
| lat_wdata | input | 5 | Page latch write data |
| jmp | input | 1 | Jump or call strobe |
| jmp_tgt | input | 11 | Jump or call target field |
| ret | input | 1 | Return strobe |
| ret_addr | input | 13 | Return address popped from the stack |
| pc | output | 13 | Current fetch address |
| pc_lo | output | 8 | Readable low byte of the address |

## Verification
The bench stresses the cases a careless design would get wrong.

- **Carry on increment.** It increments across 0x1AFF. A design that let the carry stop at the low byte would land on 0x1A00 instead of 0x1B00.
- **Wrap at the top.** It wraps 0x1FFF to zero.
- **Latch write in the same cycle.** It writes the latch in the same cycle as a low-byte write. A design that forwarded the new latch value would show the wrong upper bits.
- **Page bits on a jump.** It checks the jump page bits after the latch has changed. A design that took bits 12:11 from the old address would keep the stale page.
- **Coinciding strobes.** It applies groups of strobes together to expose a wrong priority order.
- **Reset of the latch.** It resets in the middle of a run and then does a low-byte write. A design that did not clear the latch would put non-zero upper bits back into the address.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

   // Source selected for the next fetch address, highest priority first.
   typedef enum logic [2:0] {
      SRC_RET  = 3'd0,
      SRC_JMP  = 3'd1,
      SRC_LOW  = 3'd2,
      SRC_INC  = 3'd3,
      SRC_HOLD = 3'd4
   } pc_src_e;

endpackage

// File: rtl/pgpc_arb.sv
module pgpc_arb
   import pgpc_pkg::*;
(
   input  logic    ret,
   input  logic    jmp,
   input  logic    lo_we,
   input  logic    adv,
   output pc_src_e src
);

   always_comb begin
      if (ret)        src = SRC_RET;
      else if (jmp)   src = SRC_JMP;
      else if (lo_we) src = SRC_LOW;
      else if (adv)   src = SRC_INC;
      else            src = SRC_HOLD;
   end

endmodule

// File: rtl/pgpc_latch.sv
module pgpc_latch #(
   parameter int unsigned LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [LAT_W-1:0] wdata,
   output logic [LAT_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

   // R7: the latch moves only through its own write port
   a_r7_latch_port_only: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/pgpc_next.sv
module pgpc_next
   import pgpc_pkg::*;
#(
   parameter int unsigned PC_W = 13,
   parameter int unsigned LO_W = 8,
   parameter int unsigned JT_W = 11
) (
   input  pc_src_e               src,
   input  logic [PC_W-1:0]       pc_q,
   input  logic [PC_W-LO_W-1:0]  lat_q,
   input  logic [LO_W-1:0]       lo_wdata,
   input  logic [JT_W-1:0]       jmp_tgt,
   input  logic [PC_W-1:0]       ret_addr,
   output logic [PC_W-1:0]       pc_d
);

   localparam int unsigned HI_W   = PC_W - LO_W;
   localparam int unsigned PAGE_W = PC_W - JT_W;

   logic [PC_W-1:0] jmp_val;
   logic [PC_W-1:0] low_val;
   logic [PC_W-1:0] inc_val;

   // The page bits come from the top of the latch. With a full-width
   // target field no page bits are needed.
   generate
      if (PAGE_W == 0) begin : g_flat
         assign jmp_val = jmp_tgt;
      end else begin : g_paged
         assign jmp_val = {lat_q[HI_W-1 -: PAGE_W], jmp_tgt};
      end
   endgenerate

   assign low_val = {lat_q, lo_wdata};
   assign inc_val = pc_q + PC_W'(1);

   always_comb begin
      unique case (src)
         SRC_RET: pc_d = ret_addr;
         SRC_JMP: pc_d = jmp_val;
         SRC_LOW: pc_d = low_val;
         SRC_INC: pc_d = inc_val;
         default: pc_d = pc_q;
      endcase
   end

endmodule

// File: rtl/pgpc_unit.sv
module pgpc_unit #(
   parameter int unsigned PC_W = 13,
   parameter int unsigned LO_W = 8,
   parameter int unsigned JT_W = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adv,
   input  logic                  lo_we,
   input  logic [LO_W-1:0]       lo_wdata,
   input  logic                  lat_we,
   input  logic [PC_W-LO_W-1:0]  lat_wdata,
   input  logic                  jmp,
   input  logic [JT_W-1:0]       jmp_tgt,
   input  logic                  ret,
   input  logic [PC_W-1:0]       ret_addr,
   output logic [PC_W-1:0]       pc,
   output logic [LO_W-1:0]       pc_lo
);
   import pgpc_pkg::*;

   localparam int unsigned HI_W   = PC_W - LO_W;
   localparam int unsigned PAGE_W = PC_W - JT_W;

   // Elaboration-time parameter checks
   generate
      if (LO_W == 0 || PC_W <= LO_W) begin : g_bad_lo
         $error("pgpc_unit: LO_W must be in 1..PC_W-1");
      end
      if (JT_W == 0 || JT_W > PC_W) begin : g_bad_jt
         $error("pgpc_unit: JT_W must be in 1..PC_W");
      end
      if (PAGE_W > HI_W) begin : g_bad_page
         $error("pgpc_unit: page bits exceed the latch width");
      end
   endgenerate

   pc_src_e          src;
   logic [HI_W-1:0]  lat_q;
   logic [PC_W-1:0]  pc_d;
   logic [PC_W-1:0]  pc_q;

   pgpc_arb u_arb (
      .ret   (ret),
      .jmp   (jmp),
      .lo_we (lo_we),
      .adv   (adv),
      .src   (src)
   );

   pgpc_latch #(.LAT_W(HI_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lat_we),
      .wdata (lat_wdata),
      .q     (lat_q)
   );

   pgpc_next #(.PC_W(PC_W), .LO_W(LO_W), .JT_W(JT_W)) u_next (
      .src      (src),
      .pc_q     (pc_q),
      .lat_q    (lat_q),
      .lo_wdata (lo_wdata),
      .jmp_tgt  (jmp_tgt),
      .ret_addr (ret_addr),
      .pc_d     (pc_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign pc    = pc_q;
   assign pc_lo = pc_q[LO_W-1:0];

   // R6: a return takes the popped address in full
   a_r6_return_load: assert property (@(posedge clk) disable iff (!rst_n)
      ret |=> pc == $past(ret_addr));

   // R5: a jump takes its low bits from the target field
   a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret && jmp) |=> pc[JT_W-1:0] == $past(jmp_tgt));

   // R5: the jump page bits come from the top of the latch
   generate
      if (PAGE_W > 0) begin : g_page_chk
         a_r5_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
            (!ret && jmp) |=> pc[PC_W-1 -: PAGE_W] == $past(lat_q[HI_W-1 -: PAGE_W]));
      end
   endgenerate

   // R4: a low-byte write loads the old latch together with the data
   a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret && !jmp && lo_we) |=> pc == {$past(lat_q), $past(lo_wdata)});

   // R2: increment with wrap
   a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret && !jmp && !lo_we && adv) |=> pc == $past(pc) + PC_W'(1));

   // R3 and R10: with no fetch strobe the address holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret && !jmp && !lo_we && !adv) |=> $stable(pc));

   // R9: readable low byte tracks the address
   a_r9_low_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      pc_lo == pc[LO_W-1:0]);

endmodule

// File: tb/tb_pgpc_unit.sv
module tb_pgpc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv = 1'b0, lo_we = 1'b0, lat_we = 1'b0, jmp = 1'b0, ret = 1'b0;
   logic [7:0]  lo_wdata = '0;
   logic [4:0]  lat_wdata = '0;
   logic [10:0] jmp_tgt = '0;
   logic [12:0] ret_addr = '0;
   logic [12:0] pc;
   logic [7:0]  pc_lo;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pgpc_unit dut (
      .clk(clk), .rst_n(rst_n), .adv(adv), .lo_we(lo_we), .lo_wdata(lo_wdata),
      .lat_we(lat_we), .lat_wdata(lat_wdata), .jmp(jmp), .jmp_tgt(jmp_tgt),
      .ret(ret), .ret_addr(ret_addr), .pc(pc), .pc_lo(pc_lo)
   );

   // Vector layout: ret jmp lo_we adv lat_we | lat[4:0] | lo[7:0] | tgt[10:0] | ra[12:0] | exp[12:0]
   localparam int NV = 18;
   localparam logic [54:0] VEC [NV] = '{
      {5'b00010, 5'h00, 8'h00, 11'h000, 13'h0000, 13'h0001},
      {5'b00010, 5'h00, 8'h00, 11'h000, 13'h0000, 13'h0002},
      {5'b00000, 5'h00, 8'h00, 11'h000, 13'h0000, 13'h0002},
      {5'b00001, 5'h1A, 8'h00, 11'h000, 13'h0000, 13'h0002},
      {5'b00100, 5'h00, 8'h34, 11'h000, 13'h0000, 13'h1A34},
      {5'b00010, 5'h00, 8'h00, 11'h000, 13'h0000, 13'h1A35},
      {5'b01000, 5'h00, 8'h00, 11'h2AB, 13'h0000, 13'h1AAB},
      {5'b10000, 5'h00, 8'h00, 11'h000, 13'h0123, 13'h0123},
      {5'b00100, 5'h00, 8'hFF, 11'h000, 13'h0000, 13'h1AFF},
      {5'b00010, 5'h00, 8'h00, 11'h000, 13'h0000, 13'h1B00},
      {5'b11110, 5'h00, 8'h99, 11'h005, 13'h0777, 13'h0777},
      {5'b01110, 5'h00, 8'h99, 11'h005, 13'h0000, 13'h1805},
      {5'b00111, 5'h03, 8'h10, 11'h000, 13'h0000, 13'h1A10},
      {5'b01000, 5'h00, 8'h00, 11'h7FF, 13'h0000, 13'h07FF},
      {5'b00100, 5'h00, 8'h42, 11'h000, 13'h0000, 13'h0342},
      {5'b00001, 5'h1F, 8'h00, 11'h000, 13'h0000, 13'h0342},
      {5'b00100, 5'h00, 8'hFF, 11'h000, 13'h0000, 13'h1FFF},
      {5'b00010, 5'h00, 8'h00, 11'h000, 13'h0000, 13'h0000}
   };

   function automatic string req_of(int i);
      case (i)
         0, 1:   return "R2 increment";
         2:      return "R3 hold";
         3, 15:  return "R10 latch-only write";
         4, 14:  return "R4 low write";
         5:      return "R2 increment";
         6, 13:  return "R5 jump page";
         7:      return "R6 return";
         8:      return "R7 latch kept";
         9:      return "R2 carry";
         10, 11: return "R8 priority";
         12:     return "R4 old latch";
         16:     return "R4 full page";
         default: return "R2 wrap";
      endcase
   endfunction

   task automatic check(string req, logic [12:0] act, logic [12:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: pc actual %h expected %h", req, act, exp);
      end
      checks++;
      if (pc_lo !== act[7:0]) begin
         errors++;
         $display("FAIL R9 low mirror: pc_lo actual %h expected %h", pc_lo, act[7:0]);
      end
   endtask

   task automatic idle();
      adv = 0; lo_we = 0; lat_we = 0; jmp = 0; ret = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", pc, 13'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset hold", pc, 13'h0000);

      for (int i = 0; i < NV; i++) begin
         {ret, jmp, lo_we, adv, lat_we} = VEC[i][54:50];
         lat_wdata = VEC[i][49:45];
         lo_wdata  = VEC[i][44:37];
         jmp_tgt   = VEC[i][36:26];
         ret_addr  = VEC[i][25:13];
         @(negedge clk);
         check(req_of(i), pc, VEC[i][12:0]);
      end
      idle();

      // R1: reset mid-run clears the latch as well as the address
      lat_we = 1; lat_wdata = 5'h1F; adv = 1;
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", pc, 13'h0000);
      rst_n = 1'b1;
      lo_we = 1; lo_wdata = 8'h55;
      @(negedge clk);
      idle();
      check("R1 latch cleared", pc, 13'h0055);

      // R7: a jump does not disturb the latch
      lat_we = 1; lat_wdata = 5'h12;
      @(negedge clk);
      idle();
      jmp = 1; jmp_tgt = 11'h100;
      @(negedge clk);
      idle();
      check("R5 jump page 10", pc, 13'h1100);
      lo_we = 1; lo_wdata = 8'h01;
      @(negedge clk);
      idle();
      check("R7 latch after jump", pc, 13'h1201);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule